// File: doc/BRIEF.md
# Indirect Multichannel DMA Register File

This block is the software-visible control store of a twenty-channel DMA engine. A processor reaches it through a plain word-addressed read/write bus. Only a handful of global words sit at fixed addresses. Every per-channel register (control, interrupt mask, event status, descriptor base and descriptor count) shares one window of addresses. The channel-select word decides which channel that window currently reaches, so the address space stays the same size however many channels are built.

The data movers are not part of this block. They report completion and error conditions as single-cycle event pulses, six per channel. The block latches those pulses as sticky status bits, which software clears by writing ones. Each channel drives its own interrupt line, gated first by its private mask and then by a global per-channel enable word. A channel reset, requested through the control word, runs for a fixed number of cycles. While it runs, the request bit reads back as set, so software can poll until it drops.

Top module: `dma_chan_regfile`

## Requirements
- R1: Word address 1 holds the channel index that the window at word addresses 8 to 12 reaches. A write of an index of 20 or more leaves the held index unchanged.
- R2: At word address 8, bit 0 is the channel enable. It reads back the value last written, except as R3 and R9 state.
- R3: Writing bit 1 = 1 at word address 8 starts a channel reset. Bit 1 reads 1 in each of the 4 cycles after that write and 0 afterwards. While bit 1 reads 1, bit 0 reads 0 and writes to bit 0 have no effect.
- R4: Each of the six event pulses of a channel sets one status bit. Event k appears at bit k+1 of word address 10, and the bit stays set until it is cleared.
- R5: Writing word address 10 clears each status bit whose data bit is 1, so 0x7E clears all of them. An event that arrives in the same cycle as the clear still sets its bit.
- R6: While a channel reset runs (R3), and in the cycle that requests it, that channel's status is cleared and its events are dropped.
- R7: Word address 9 holds a six-bit interrupt mask in bits 6..1, and word address 2 holds one global enable bit per channel. Interrupt line n is high when channel n has a status bit that is both set and masked on, and global enable bit n is 1.
- R8: Word address 11 holds a 32-bit descriptor base. Word address 12 holds an 8-bit descriptor count that is 25 after reset.
- R9: Writing bit 0 = 1 at word address 0 returns every register of every channel, the select word and the global enable word to their reset values by the next cycle. Word address 0 reads as 0.
- R10: Reads of word addresses other than 0, 1, 2 and 8 to 12 return 0, and writes to them change no state. When the read strobe is low, the read data is 0.
- R11: After reset, every register reads 0 except the descriptor count, which reads 25, and every interrupt line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| chan_evt | input | 120 | Event pulses, six per channel, channel n at bits 6n+5..6n |
| chan_irq | output | 20 | Interrupt line per channel |

## Verification
The assertions assume that the address and strobes are settled before each clock edge, and that event pulses are ordinary single-cycle levels that the block samples at the edge. They also assume that the global reset word is written only occasionally, so that reset countdowns and sticky bits have time to show their behaviour. The bench drives every input half a cycle before the edge. It writes the global reset word with bit 0 set in about one write in fifty, and limits random select values to a range just past the channel count, so that both valid and out-of-range indices occur. Event vectors are kept sparse by combining several random words with AND, so that status bits build up and get cleared instead of saturating.

// File: rtl/dmachreg_pkg.sv
`timescale 1ns/1ps
package dmachreg_pkg;

    // word addresses of the register window
    localparam int ADR_GCTRL = 0;
    localparam int ADR_CSEL  = 1;
    localparam int ADR_GIEN  = 2;
    localparam int ADR_CCTRL = 8;
    localparam int ADR_CIEN  = 9;
    localparam int ADR_CSTAT = 10;
    localparam int ADR_CBASE = 11;
    localparam int ADR_CCNT  = 12;

    typedef struct packed {
        logic gctrl;
        logic csel;
        logic gien;
        logic cctrl;
        logic cien;
        logic cstat;
        logic cbase;
        logic ccnt;
    } reg_hit_t;

    typedef struct packed {
        logic ctrl;
        logic ien;
        logic stat;
        logic base;
        logic cnt;
    } chan_wr_t;

endpackage

// File: rtl/dmachreg_decode.sv
`timescale 1ns/1ps
module dmachreg_decode
    import dmachreg_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_hit_t          hit
);

    always_comb begin
        hit = '0;
        case (addr)
            ADDR_W'(ADR_GCTRL): hit.gctrl = 1'b1;
            ADDR_W'(ADR_CSEL):  hit.csel  = 1'b1;
            ADDR_W'(ADR_GIEN):  hit.gien  = 1'b1;
            ADDR_W'(ADR_CCTRL): hit.cctrl = 1'b1;
            ADDR_W'(ADR_CIEN):  hit.cien  = 1'b1;
            ADDR_W'(ADR_CSTAT): hit.cstat = 1'b1;
            ADDR_W'(ADR_CBASE): hit.cbase = 1'b1;
            ADDR_W'(ADR_CCNT):  hit.ccnt  = 1'b1;
            default: ;
        endcase
    end

    // R10
    always_comb begin
        onehot_hit_chk: assert ($onehot0(hit));
    end

endmodule

// File: rtl/dmachreg_chan.sv
`timescale 1ns/1ps
module dmachreg_chan
    import dmachreg_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int EVT_W   = 6,
    parameter int CNT_W   = 8,
    parameter int CNT_RST = 25,
    parameter int RST_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              glob_clr,
    input  chan_wr_t          wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [EVT_W-1:0]  evt,
    output logic              en,
    output logic              busy,
    output logic [EVT_W-1:0]  ien,
    output logic [EVT_W-1:0]  stat,
    output logic [DATA_W-1:0] base,
    output logic [CNT_W-1:0]  cnt,
    output logic              irq_src
);

    localparam int RC_W = $clog2(RST_CYC + 1);

    typedef struct packed {
        logic              en;
        logic [RC_W-1:0]   rc;
        logic [EVT_W-1:0]  ien;
        logic [EVT_W-1:0]  stat;
        logic [DATA_W-1:0] base;
        logic [CNT_W-1:0]  cnt;
    } chan_st_t;

    localparam chan_st_t ST_INIT = '{
        en:   1'b0,
        rc:   '0,
        ien:  '0,
        stat: '0,
        base: '0,
        cnt:  CNT_W'(CNT_RST)
    };

    chan_st_t s_d, s_q;
    logic     rst_req;

    assign rst_req = wr.ctrl & wdata[1];

    always_comb begin
        s_d = s_q;
        if (s_q.rc != '0) s_d.rc = s_q.rc - 1'b1;
        s_d.stat = s_q.stat | evt;
        if (wr.stat) s_d.stat = (s_q.stat & ~wdata[EVT_W:1]) | evt;
        if (wr.ctrl) s_d.en = wdata[0];
        if (rst_req) s_d.rc = RC_W'(RST_CYC);
        if (wr.ien)  s_d.ien  = wdata[EVT_W:1];
        if (wr.base) s_d.base = wdata;
        if (wr.cnt)  s_d.cnt  = wdata[CNT_W-1:0];
        if ((s_q.rc != '0) || rst_req) begin
            s_d.en   = 1'b0;
            s_d.stat = '0;
        end
        if (glob_clr) s_d = ST_INIT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= ST_INIT;
        else        s_q <= s_d;
    end

    assign en      = s_q.en;
    assign busy    = (s_q.rc != '0);
    assign ien     = s_q.ien;
    assign stat    = s_q.stat;
    assign base    = s_q.base;
    assign cnt     = s_q.cnt;
    assign irq_src = |(s_q.stat & s_q.ien);

    // R3
    rst_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rst_req && !glob_clr) |=> (s_q.rc == $past(s_q.rc) - 1'b1));

    // R3
    busy_holds_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !en);

    // R6
    busy_no_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (stat == '0));

    // R4
    evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !rst_req && !glob_clr) |=> ((stat & $past(evt)) == $past(evt)));

    // R5
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr.stat && !glob_clr) |=>
            ((stat & ~$past(evt) & $past(wdata[EVT_W:1])) == '0));

endmodule

// File: rtl/dma_chan_regfile.sv
`timescale 1ns/1ps
module dma_chan_regfile
    import dmachreg_pkg::*;
#(
    parameter int NUM_CH  = 20,
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 32,
    parameter int EVT_W   = 6,
    parameter int CNT_W   = 8,
    parameter int CNT_RST = 25,
    parameter int RST_CYC = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    input  logic [NUM_CH*EVT_W-1:0] chan_evt,
    output logic [NUM_CH-1:0]       chan_irq
);

    localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [NUM_CH-1:0] gie;
    } top_st_t;

    top_st_t  t_d, t_q;
    reg_hit_t hit;
    logic     glob_clr;

    logic [NUM_CH-1:0]             ch_en, ch_busy, ch_irqsrc;
    logic [NUM_CH-1:0][EVT_W-1:0]  ch_ien, ch_stat;
    logic [NUM_CH-1:0][DATA_W-1:0] ch_base;
    logic [NUM_CH-1:0][CNT_W-1:0]  ch_cnt;
    logic [DATA_W-1:0]             rd_val;

    dmachreg_decode #(.ADDR_W(ADDR_W)) i_decode (
        .addr (bus_addr),
        .hit  (hit)
    );

    assign glob_clr = bus_wr & hit.gctrl & bus_wdata[0];

    always_comb begin
        t_d = t_q;
        if (bus_wr && hit.csel && (bus_wdata < DATA_W'(NUM_CH)))
            t_d.sel = bus_wdata[SEL_W-1:0];
        if (bus_wr && hit.gien)
            t_d.gie = bus_wdata[NUM_CH-1:0];
        if (glob_clr) t_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        chan_wr_t cw;
        logic     pick;
        assign pick    = bus_wr & (t_q.sel == SEL_W'(g));
        assign cw.ctrl = pick & hit.cctrl;
        assign cw.ien  = pick & hit.cien;
        assign cw.stat = pick & hit.cstat;
        assign cw.base = pick & hit.cbase;
        assign cw.cnt  = pick & hit.ccnt;

        dmachreg_chan #(
            .DATA_W  (DATA_W),
            .EVT_W   (EVT_W),
            .CNT_W   (CNT_W),
            .CNT_RST (CNT_RST),
            .RST_CYC (RST_CYC)
        ) i_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .glob_clr (glob_clr),
            .wr       (cw),
            .wdata    (bus_wdata),
            .evt      (chan_evt[g*EVT_W +: EVT_W]),
            .en       (ch_en[g]),
            .busy     (ch_busy[g]),
            .ien      (ch_ien[g]),
            .stat     (ch_stat[g]),
            .base     (ch_base[g]),
            .cnt      (ch_cnt[g]),
            .irq_src  (ch_irqsrc[g])
        );
    end

    assign chan_irq = ch_irqsrc & t_q.gie;

    always_comb begin
        rd_val = '0;
        unique case (1'b1)
            hit.csel:  rd_val = DATA_W'(t_q.sel);
            hit.gien:  rd_val = DATA_W'(t_q.gie);
            hit.cctrl: rd_val = DATA_W'({ch_busy[t_q.sel], ch_en[t_q.sel]});
            hit.cien:  rd_val = DATA_W'({ch_ien[t_q.sel], 1'b0});
            hit.cstat: rd_val = DATA_W'({ch_stat[t_q.sel], 1'b0});
            hit.cbase: rd_val = ch_base[t_q.sel];
            hit.ccnt:  rd_val = DATA_W'(ch_cnt[t_q.sel]);
            default:   rd_val = '0;
        endcase
    end

    assign bus_rdata = bus_rd ? rd_val : '0;

    // R1
    sel_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.sel < SEL_W'(NUM_CH));

    // R9
    glob_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        glob_clr |=> ((t_q.gie == '0) && (t_q.sel == '0) && (chan_irq == '0)));

    // R10
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));

endmodule

// File: tb/test_dma_chan_regfile.sv
`timescale 1ns/1ps
module test_dma_chan_regfile;

    localparam int NCH = 20;
    localparam int EW  = 6;
    localparam int RC  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [5:0]        addr = '0;
    logic [31:0]       wdata = '0;
    logic [NCH*EW-1:0] evt = '0;
    logic [31:0]       rdata;
    logic [NCH-1:0]    irq;

    int total = 0;
    int bad = 0;
    logic [31:0] last_rd;

    // bench model of the register file
    bit          m_en [NCH];
    int          m_rc [NCH];
    logic [5:0]  m_ie [NCH];
    logic [5:0]  m_st [NCH];
    logic [31:0] m_base [NCH];
    logic [7:0]  m_cnt [NCH];
    int          m_sel;
    logic [NCH-1:0] m_gie;

    dma_chan_regfile i_dma_chan_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (wr_en),
        .bus_rd    (rd_en),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .chan_evt  (evt),
        .chan_irq  (irq)
    );

    always #10 clk = ~clk;

    function automatic void model_reset();
        for (int i = 0; i < NCH; i++) begin
            m_en[i] = 1'b0; m_rc[i] = 0; m_ie[i] = '0; m_st[i] = '0;
            m_base[i] = '0; m_cnt[i] = 8'd25;
        end
        m_sel = 0;
        m_gie = '0;
    endfunction

    function automatic logic [31:0] exp_read(logic [5:0] a);
        case (a)
            6'd1:  return 32'(m_sel);
            6'd2:  return 32'(m_gie);
            6'd8:  return {30'b0, (m_rc[m_sel] != 0), m_en[m_sel]};
            6'd9:  return {25'b0, m_ie[m_sel], 1'b0};
            6'd10: return {25'b0, m_st[m_sel], 1'b0};
            6'd11: return m_base[m_sel];
            6'd12: return {24'b0, m_cnt[m_sel]};
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [NCH-1:0] exp_irq();
        logic [NCH-1:0] v;
        for (int i = 0; i < NCH; i++) v[i] = ((m_st[i] & m_ie[i]) != 0) && m_gie[i];
        return v;
    endfunction

    function automatic string req_of(logic [5:0] a);
        case (a)
            6'd0: return "R9";
            6'd1: return "R1";
            6'd2: return "R7";
            6'd8: return "R3";
            6'd9: return "R7";
            6'd10: return "R5";
            6'd11, 6'd12: return "R8";
            default: return "R10";
        endcase
    endfunction

    function automatic void model_step(bit w, logic [5:0] a, logic [31:0] d,
                                       logic [NCH*EW-1:0] ev);
        if (w && a == 6'd0 && d[0]) begin
            model_reset();
            return;
        end
        for (int i = 0; i < NCH; i++) begin
            bit   me  = w && (i == m_sel);
            bit   req = me && a == 6'd8 && d[1];
            int   nr  = (m_rc[i] > 0) ? m_rc[i] - 1 : 0;
            logic [5:0] evi = ev[i*EW +: EW];
            logic [5:0] st  = m_st[i] | evi;
            bit   en  = m_en[i];
            if (me && a == 6'd10) st = (m_st[i] & ~d[6:1]) | evi;
            if (me && a == 6'd8) en = d[0];
            if (req) nr = RC;
            if (me && a == 6'd9)  m_ie[i] = d[6:1];
            if (me && a == 6'd11) m_base[i] = d;
            if (me && a == 6'd12) m_cnt[i] = d[7:0];
            if (m_rc[i] != 0 || req) begin
                en = 1'b0;
                st = '0;
            end
            m_en[i] = en; m_st[i] = st; m_rc[i] = nr;
        end
        if (w && a == 6'd1 && d < NCH) m_sel = int'(d);
        if (w && a == 6'd2) m_gie = d[NCH-1:0];
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(bit w, bit r, logic [5:0] a, logic [31:0] d,
                       logic [NCH*EW-1:0] ev);
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d; evt = ev;
        #2;
        last_rd = rdata;
        if (r) chk(req_of(a), rdata, exp_read(a));
        chk("R7 irq", 32'(irq), 32'(exp_irq()));
        model_step(w, a, d, ev);
        @(posedge clk);
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        cyc(1'b1, 1'b0, a, d, '0);
    endtask

    task automatic rd(logic [5:0] a);
        cyc(1'b0, 1'b1, a, 32'd0, '0);
    endtask

    function automatic logic [NCH*EW-1:0] ev_for(int ch, logic [5:0] bits);
        logic [NCH*EW-1:0] v = '0;
        v[ch*EW +: EW] = bits;
        return v;
    endfunction

    initial begin
        #(200000 * 20);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R11 reset state
        for (int a = 0; a < 16; a++) rd(6'(a));
        rd(6'd12); chk("R11 count", last_rd, 32'd25);
        rd(6'd8);  chk("R11 ctrl", last_rd, 32'd0);
        chk("R11 irq", 32'(irq), 32'd0);

        // R1 select, out-of-range ignored
        wr(6'd1, 32'd7); rd(6'd1); chk("R1 sel", last_rd, 32'd7);
        wr(6'd1, 32'd25); rd(6'd1); chk("R1 sel range", last_rd, 32'd7);
        wr(6'd1, 32'd19); wr(6'd11, 32'hCAFE_0010); wr(6'd12, 32'd3);
        rd(6'd11); chk("R8 base", last_rd, 32'hCAFE_0010);
        wr(6'd1, 32'd3);
        rd(6'd11); chk("R8 base other ch", last_rd, 32'd0);

        // R2 enable
        wr(6'd8, 32'd1); rd(6'd8); chk("R2 en", last_rd, 32'd1);

        // R3 reset handshake and R6 event drop
        wr(6'd8, 32'd3);
        cyc(1'b0, 1'b1, 6'd8, 32'd0, ev_for(3, 6'h3F)); chk("R3 busy1", last_rd, 32'd2);
        cyc(1'b1, 1'b0, 6'd8, 32'd1, '0);
        rd(6'd8); chk("R3 busy3", last_rd, 32'd2);
        rd(6'd8); chk("R3 busy4", last_rd, 32'd2);
        rd(6'd8); chk("R3 done", last_rd, 32'd0);
        rd(6'd10); chk("R6 dropped", last_rd, 32'd0);

        // R4 sticky events, R5 clear
        cyc(1'b0, 1'b0, 6'd0, 32'd0, ev_for(3, 6'b000101));
        rd(6'd10); chk("R4 sticky", last_rd, 32'h0A);
        cyc(1'b1, 1'b0, 6'd10, 32'h7E, ev_for(3, 6'b100000));
        rd(6'd10); chk("R5 set wins", last_rd, 32'h40);
        wr(6'd10, 32'h7E); rd(6'd10); chk("R5 clear all", last_rd, 32'd0);

        // R7 interrupt gating
        cyc(1'b0, 1'b0, 6'd0, 32'd0, ev_for(3, 6'b000010));
        wr(6'd9, 32'h04); rd(6'd9);
        chk("R7 gie off", 32'(irq), 32'd0);
        wr(6'd2, 32'h8);
        rd(6'd2); chk("R7 irq on", 32'(irq), 32'h8);
        wr(6'd10, 32'h04); rd(6'd10); chk("R7 irq off", 32'(irq), 32'd0);

        // R10 unmapped
        wr(6'd5, 32'hFFFF_FFFF); rd(6'd5); chk("R10 unmapped", last_rd, 32'd0);
        rd(6'd2); chk("R10 no side effect", last_rd, 32'h8);

        // R9 global reset
        cyc(1'b0, 1'b0, 6'd0, 32'd0, ev_for(3, 6'h3F));
        wr(6'd0, 32'd1);
        rd(6'd0); chk("R9 gctrl read", last_rd, 32'd0);
        rd(6'd2); chk("R9 gie", last_rd, 32'd0);
        rd(6'd12); chk("R9 count", last_rd, 32'd25);
        rd(6'd1); chk("R9 sel", last_rd, 32'd0);

        // constrained random traffic
        for (int n = 0; n < 6000; n++) begin
            bit w = ($urandom % 2) == 1;
            bit r = !w || (($urandom % 2) == 1);
            logic [5:0]  a = 6'($urandom % 16);
            logic [31:0] d = $urandom;
            logic [NCH*EW-1:0] ev;
            for (int k = 0; k < 4; k++)
                ev[k*30 +: 30] = 30'($urandom & $urandom & $urandom & $urandom);
            if (a == 6'd0 && ($urandom % 50) != 0) d[0] = 1'b0;
            if (a == 6'd1) d = $urandom % 24;
            if (a == 6'd2 && ($urandom % 3) != 0) d = 32'hFFFFF;
            if (a == 6'd8 && ($urandom % 4) != 0) d[1] = 1'b0;
            cyc(w, r, a, d, ev);
        end

        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; evt = '0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule